// File: doc/BRIEF.md
# Optical black clamp controller

This block closes the digital side of a black-level correction loop in an image sensor front end. Each pixel clock it may receive a 12-bit unsigned converter sample. A strobe marks the shielded dark pixels at the start of a line. While that strobe is high and the loop is on, the block adds up the difference between an 8-bit programmable black target and each sample. The target is scaled up by 4 bits into the sample range before the subtraction. When the strobe falls, the block scales the sum down by a programmable arithmetic shift, which acts as a first-order low-pass filter. It adds the result to an 8-bit correction code that feeds an offset DAC ahead of the converter.

The correction can be applied every line or only once every N lines, with N programmable. In the slower case the errors of all N windows add into the one update. A window narrower than 20 pixels raises a one-cycle warning. When the loop enable bit is low, no error is gathered and the target itself goes straight to the DAC as a fixed manual offset.

Top module: `obclamp_ctrl`

## Requirements
- R1: After synchronous reset, `dac_code` equals `blk_target` and `short_win` is 0.
- R2: While `loop_en` is 0, `dac_code` equals `blk_target` in the same cycle, and windows run in that time change nothing.
- R3: Samples presented while `clamp_win` is 0 have no effect on any later correction.
- R4: Each cycle with `clamp_win` high and `loop_en` high adds the error (`blk_target`·16 − `sample`) to a signed sum.
- R5: On the clock edge where `clamp_win` is first seen low after being high, an update adds the sum arithmetic-shifted right by `filt_shift` (rounding toward minus infinity) to the code. The new code shows on `dac_code` after that edge, and the sum then restarts from 0.
- R6: The correction code saturates at 0 and at 255 and never wraps.
- R7: An update happens only at the end of every `line_div`-th window (`line_div` of 0 or 1 means every window). Errors from the windows in between carry over into the sum.
- R8: `short_win` pulses high for exactly one cycle, at the same edge as R5, when the window just ended lasted fewer than 20 cycles. A window of 20 or more cycles gives no pulse.
- R9: When `loop_en` returns to 1, the loop starts from `blk_target` with an empty sum and a fresh line count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 12 | Unsigned converter output code |
| clamp_win | input | 1 | High during shielded dark pixels |
| blk_target | input | 8 | Programmable black-level target |
| loop_en | input | 1 | Clamp loop enable from the operation register |
| filt_shift | input | 4 | Right shift applied to the window error sum |
| line_div | input | 8 | Update once every this many windows |
| dac_code | output | 8 | Offset DAC correction code |
| short_win | output | 1 | One-cycle flag for a window under 20 cycles |

## Verification
The loop is driven with dark samples below the target, which must raise the code, and above it, which must lower it. This shows that the sign of the error is right. Windows with varied samples and stray samples outside the strobe show whether only strobed cycles are summed. Zero-shift runs at both extremes push the code against 0 and 255 to test saturation. A three-line divider, window lengths of 10, 20 and 24, and a disable/re-enable sequence that changes the target separate the line-count, short-window and manual-offset behaviour.

// File: rtl/obc_pkg.sv
package obc_pkg;
    localparam int SAMPLE_W  = 12;
    localparam int CODE_W    = 8;
    localparam int SHIFT_W   = 4;
    localparam int DIV_W     = 8;
    localparam int ACC_W     = 32;
    localparam int MIN_WIN   = 20;
    localparam int ERR_W     = SAMPLE_W + 1;
    localparam int TGT_SHIFT = SAMPLE_W - CODE_W;

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic [CODE_W-1:0]       code_t;

    typedef struct packed {
        logic fall;
        logic short_flag;
    } win_evt_t;

    // signed error of one sample against the scaled target
    function automatic acc_t pixel_err(input code_t tgt, input logic [SAMPLE_W-1:0] smp);
        logic signed [ERR_W-1:0] ref_s;
        logic signed [ERR_W-1:0] smp_s;
        ref_s = $signed({1'b0, tgt, {TGT_SHIFT{1'b0}}});
        smp_s = $signed({1'b0, smp});
        return acc_t'(ref_s - smp_s);
    endfunction

    // code plus signed step, clamped to the code range
    function automatic code_t sat_add(input code_t code, input acc_t step);
        logic signed [ACC_W:0] sum;
        logic signed [ACC_W:0] top;
        sum = $signed({{(ACC_W+1-CODE_W){1'b0}}, code}) + {step[ACC_W-1], step};
        top = $signed({{(ACC_W+1-CODE_W){1'b0}}, {CODE_W{1'b1}}});
        if (sum < 0)
            return '0;
        else if (sum > top)
            return {CODE_W{1'b1}};
        else
            return sum[CODE_W-1:0];
    endfunction
endpackage

// File: rtl/obc_window_mon.sv
module obc_window_mon
    import obc_pkg::*;
#(
    parameter int MIN_LEN = MIN_WIN
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     win,
    output win_evt_t evt
);
    localparam int LEN_W = $clog2(MIN_LEN + 1);

    logic             win_q;
    logic [LEN_W-1:0] len_q;
    logic             short_q;
    logic             fall;

    assign fall = win_q && !win;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q   <= 1'b0;
            len_q   <= '0;
            short_q <= 1'b0;
        end else begin
            win_q   <= win;
            short_q <= fall && (len_q < LEN_W'(MIN_LEN));
            if (!win)
                len_q <= '0;
            else if (len_q < LEN_W'(MIN_LEN))
                len_q <= len_q + 1'b1;
        end
    end

    assign evt.fall       = fall;
    assign evt.short_flag = short_q;

    // R8
    short_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        short_q |=> !short_q);
endmodule

// File: rtl/obc_err_accum.sv
module obc_err_accum
    import obc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                win,
    input  logic                clr,
    input  logic [SAMPLE_W-1:0] sample,
    input  code_t               target,
    output acc_t                acc
);
    acc_t acc_q;

    always_ff @(posedge clk) begin
        if (rst || !en)
            acc_q <= '0;
        else if (clr)
            acc_q <= '0;
        else if (win)
            acc_q <= acc_q + pixel_err(target, sample);
    end

    assign acc = acc_q;

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !win && !clr) |=> $stable(acc_q));
endmodule

// File: rtl/obc_code_reg.sv
module obc_code_reg
    import obc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               fall,
    input  acc_t               acc,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [DIV_W-1:0]   div,
    input  code_t              target,
    output logic               upd,
    output code_t              code
);
    logic [DIV_W-1:0] line_q;
    logic [DIV_W-1:0] div_eff;
    code_t            code_q;
    acc_t             step;

    assign div_eff = (div == '0) ? DIV_W'(1) : div;
    assign step    = acc >>> shift;
    assign upd     = en && fall && ({1'b0, line_q} + 1'b1 >= {1'b0, div_eff});

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            line_q <= '0;
            code_q <= target;
        end else if (fall) begin
            if (upd) begin
                line_q <= '0;
                code_q <= sat_add(code_q, step);
            end else begin
                line_q <= line_q + 1'b1;
            end
        end
    end

    assign code = code_q;

    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !upd) |=> $stable(code_q));

    // R6
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && !step[ACC_W-1]) |=> code_q >= $past(code_q));

    // R7
    line_range_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> line_q < div_eff);
endmodule

// File: rtl/obclamp_ctrl.sv
module obclamp_ctrl
    import obc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                clamp_win,
    input  logic [CODE_W-1:0]   blk_target,
    input  logic                loop_en,
    input  logic [SHIFT_W-1:0]  filt_shift,
    input  logic [DIV_W-1:0]    line_div,
    output logic [CODE_W-1:0]   dac_code,
    output logic                short_win
);
    win_evt_t evt;
    acc_t     acc;
    logic     upd;
    code_t    code;

    obc_window_mon #(.MIN_LEN(MIN_WIN)) u_win (
        .clk (clk),
        .rst (rst),
        .win (clamp_win),
        .evt (evt)
    );

    obc_err_accum u_acc (
        .clk    (clk),
        .rst    (rst),
        .en     (loop_en),
        .win    (clamp_win),
        .clr    (upd),
        .sample (sample),
        .target (blk_target),
        .acc    (acc)
    );

    obc_code_reg u_code (
        .clk    (clk),
        .rst    (rst),
        .en     (loop_en),
        .fall   (evt.fall),
        .acc    (acc),
        .shift  (filt_shift),
        .div    (line_div),
        .target (blk_target),
        .upd    (upd),
        .code   (code)
    );

    assign dac_code  = loop_en ? code : blk_target;
    assign short_win = evt.short_flag;

    // R5
    upd_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        upd |-> (!clamp_win && $past(clamp_win)));
endmodule

// File: tb/obclamp_ctrl_test.sv
module obclamp_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] sample;
    logic        clamp_win;
    logic [7:0]  blk_target;
    logic        loop_en;
    logic [3:0]  filt_shift;
    logic [7:0]  line_div;
    logic [7:0]  dac_code;
    logic        short_win;

    obclamp_ctrl uut (
        .clk(clk), .rst(rst), .sample(sample), .clamp_win(clamp_win),
        .blk_target(blk_target), .loop_en(loop_en), .filt_shift(filt_shift),
        .line_div(line_div), .dac_code(dac_code), .short_win(short_win)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    due;
        int    code;
        bit    shrt;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 0;

    // reference model state
    int   m_code;
    longint m_acc;
    int   m_line;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: compare scoreboard items when they fall due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " code"}, int'(dac_code), e.code);
            check({e.tag, " short"}, int'(short_win), int'(e.shrt));
        end
    end

    function automatic int sat8(input longint v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return int'(v);
    endfunction

    // driver: one dark window; samples follow base + pattern
    task automatic run_line(input int len, input int base, input int wobble, input string tag);
        longint sum = 0;
        int div;
        for (int i = 0; i < len; i++) begin
            int s;
            @(negedge clk);
            s = base + ((i % 3) - 1) * wobble;
            clamp_win = 1'b1;
            sample    = 12'(s);
            sum += longint'(blk_target) * 16 - s;
        end
        @(negedge clk);
        clamp_win = 1'b0;
        sample    = 12'd0;
        div = (line_div == 0) ? 1 : int'(line_div);
        if (loop_en) begin
            m_acc += sum;
            m_line++;
            if (m_line >= div) begin
                m_code = sat8(longint'(m_code) + (m_acc >>> filt_shift));
                m_acc  = 0;
                m_line = 0;
            end
        end else begin
            m_code = blk_target;
            m_acc  = 0;
            m_line = 0;
        end
        sb.push_back('{due: cyc + 1, code: m_code, shrt: (len < 20), tag: tag});
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; sample = '0; clamp_win = 0; blk_target = 8'd16;
        loop_en = 1'b1; filt_shift = 4'd6; line_div = 8'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_code = 16; m_acc = 0; m_line = 0;
        @(negedge clk);
        check("R1 reset code", dac_code, 16);
        check("R1 reset short", short_win, 0);

        run_line(24, 200, 0, "R4 R5 dark below target");
        run_line(24, 400, 0, "R4 R5 dark above target");

        // R3: stray samples outside the window
        repeat (6) begin
            @(negedge clk);
            sample = 12'd0;
        end
        check("R3 stray samples", dac_code, m_code);
        run_line(24, 260, 7, "R3 R4 varied window");

        run_line(10, 256, 0, "R8 short window");
        run_line(20, 256, 0, "R8 boundary 20");

        filt_shift = 4'd0;
        run_line(24, 0, 0, "R6 saturate high");
        run_line(24, 4095, 0, "R6 saturate low");

        filt_shift = 4'd4;
        line_div = 8'd3;
        run_line(24, 100, 0, "R7 line 1 of 3");
        run_line(24, 120, 0, "R7 line 2 of 3");
        run_line(24, 140, 0, "R7 line 3 of 3");
        line_div = 8'd0;
        run_line(24, 200, 3, "R7 div zero");

        // R2: disabled loop gives manual offset
        @(negedge clk);
        loop_en = 1'b0;
        blk_target = 8'd90;
        #1;
        check("R2 manual offset", dac_code, 90);
        run_line(24, 0, 0, "R2 window while off");
        blk_target = 8'd40;
        #1;
        check("R2 follows target", dac_code, 40);

        // R9: re-enable starts from target
        @(negedge clk);
        loop_en = 1'b1;
        m_code = 40; m_acc = 0; m_line = 0;
        @(negedge clk);
        check("R9 restart code", dac_code, 40);
        run_line(24, 500, 0, "R9 first line after enable");

        repeat (3) @(negedge clk);
        check("scoreboard drained", sb.size(), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule